// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the singly linked list of extended capability headers kept in a 4 KB configuration space. It has no storage for that space. Every access goes through a dword read/write port to an external memory, and a read returns its data one cycle after it is issued. A header dword carries a 16-bit capability identifier, a 4-bit version and a 12-bit byte offset to the next header. The list always starts at byte 256.

Two commands are accepted, one at a time.

- **Find** follows the chain from the list head until the identifier matches or the chain ends. It reports whether the entry was found, its offset, and the offset of the entry before it.
- **Append** adds a new header. Appending at byte 256 replaces the head header but keeps the head's existing link. Appending anywhere else first locates the last entry, using identifier 0 as a key that can never match. It then rewrites that entry's link to point at the new header, and writes the new header with a zero link.

Malformed lists and bad arguments end the command with an error flag. The list is malformed when a link points outside the legal window or when the chain is longer than the step limit, which is how a cyclic list is caught.

Top module: `capw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `found` and `err` are all low.
- R2: If the dword at byte offset 256 is zero, a find completes with `found`=0, `res_off`=0 and `res_prev`=0.
- R3: A header holds the identifier in bits [15:0], the version in bits [19:16] and the next-entry byte offset in bits [31:20]. A find of a nonzero identifier completes with `found`=1, `res_off` set to the matching header's offset and `res_prev` set to the previous header's offset (0 when the match is the head at 256).
- R4: A find that reaches a header whose link is 0 without a match reports `found`=0, `res_off`=0 and `res_prev` set to that last header's offset. Identifier 0 never matches, so a find of 0 returns the tail this way.
- R5: Any link the walk would follow must lie in the range 256 to CFG_BYTES−8, which is 4088 by default, inclusive. A link outside that range ends the command with `err`=1, `found`=0, `res_off`=0 and `res_prev`=0.
- R6: A walk reads at most MAX_STEPS headers. If the last of them still links onward without a match, the command ends with `err`=1. This ends walks over a cyclic list.
- R7: An append at offset 256 writes one header at 256: the command's identifier and version, plus the link field that was already stored there. It reports `err`=0, `res_off`=256 and `res_prev`=0.
- R8: An append at any other offset does three things. It rewrites the tail header's link to the new offset, keeping the tail's identifier and version. It writes the new header with a zero link. It reports `res_off` as the new offset and `res_prev` as the tail's offset. On an empty list it ends with `err`=1 and writes nothing.
- R9: An append ends with `err`=1 and no memory write in any of these cases: size below 8, offset plus size above CFG_BYTES, offset below 256, or offset not a multiple of 4. Offset plus size equal to CFG_BYTES is accepted.
- R10: `done` pulses for exactly one cycle per accepted command. `busy` is high from acceptance until that pulse. A `cmd_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start a command (accepted when not busy) |
| cmd_op | input | 1 | 0 = find, 1 = append |
| cmd_id | input | 16 | Capability identifier to search for or to append |
| cmd_ver | input | 4 | Version of the appended header |
| cmd_off | input | 12 | Byte offset of the appended header |
| cmd_size | input | 13 | Byte size of the appended capability |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Find matched an entry |
| res_off | output | 12 | Match offset (find) or new header offset (append) |
| res_prev | output | 12 | Offset of the preceding entry |
| err | output | 1 | Command ended on an error |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Dword address into configuration space |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |

## Verification
The bench builds the walker with MAX_STEPS set to 6 and keeps the default 256-byte base and 4096-byte space. With that limit, a chain of exactly six headers is accepted, while a seventh header or a two-entry cycle is rejected, and each of these walks takes only a few dozen cycles. The default space size keeps the edge cases reachable: a link to 4088 against one to 4092, and an append whose end lands exactly on byte 4096.

// File: rtl/capw_pkg.sv
package capw_pkg;

    localparam int ID_W  = 16;
    localparam int VER_W = 4;
    localparam int NXT_W = 12;
    localparam int HDR_W = ID_W + VER_W + NXT_W;

    typedef struct packed {
        logic [NXT_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } capw_hdr_t;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_READ    = 3'd1,
        S_CHECK   = 3'd2,
        S_WR_TAIL = 3'd3,
        S_WR_NEW  = 3'd4
    } capw_state_e;

    localparam logic OP_FIND   = 1'b0;
    localparam logic OP_APPEND = 1'b1;

endpackage

// File: rtl/capw_link_check.sv
// Decides whether a link pointer lies inside the legal header window.
module capw_link_check #(
    parameter int unsigned BASE_OFF  = 256,
    parameter int unsigned CFG_BYTES = 4096,
    parameter int unsigned OFF_W     = 12
) (
    input  logic [OFF_W-1:0] ptr,
    output logic             in_range
);
    localparam int unsigned     LAST_OFF = CFG_BYTES - 8;
    localparam logic [OFF_W:0]  LO_LIM   = (OFF_W+1)'(BASE_OFF);
    localparam logic [OFF_W:0]  HI_LIM   = (OFF_W+1)'(LAST_OFF);

    logic [OFF_W:0] ptr_w;

    assign ptr_w    = {1'b0, ptr};
    assign in_range = (ptr_w >= LO_LIM) && (ptr_w <= HI_LIM);
endmodule

// File: rtl/capw_arg_check.sv
// Validates the placement arguments of an append command.
module capw_arg_check #(
    parameter int unsigned BASE_OFF  = 256,
    parameter int unsigned CFG_BYTES = 4096,
    parameter int unsigned MIN_SIZE  = 8,
    parameter int unsigned OFF_W     = 12
) (
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W:0]   size,
    output logic             args_ok
);
    localparam int unsigned      SUM_W  = OFF_W + 2;
    localparam logic [SUM_W-1:0] END_LIM = SUM_W'(CFG_BYTES);
    localparam logic [SUM_W-1:0] LO_LIM  = SUM_W'(BASE_OFF);
    localparam logic [SUM_W-1:0] MIN_LIM = SUM_W'(MIN_SIZE);

    logic [SUM_W-1:0] off_w;
    logic [SUM_W-1:0] size_w;
    logic [SUM_W-1:0] end_w;

    assign off_w   = {2'b00, off};
    assign size_w  = {1'b0, size};
    assign end_w   = off_w + size_w;
    assign args_ok = (size_w >= MIN_LIM) && (end_w <= END_LIM) &&
                     (off_w >= LO_LIM) && (off[1:0] == 2'b00);
endmodule

// File: rtl/capw_walker.sv
module capw_walker
    import capw_pkg::*;
#(
    parameter int unsigned BASE_OFF  = 256,
    parameter int unsigned CFG_BYTES = 4096,
    parameter int unsigned MAX_STEPS = 1024,
    parameter int unsigned MIN_SIZE  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic                        cmd_op,
    input  logic [ID_W-1:0]             cmd_id,
    input  logic [VER_W-1:0]            cmd_ver,
    input  logic [NXT_W-1:0]            cmd_off,
    input  logic [NXT_W:0]              cmd_size,
    output logic                        busy,
    output logic                        done,
    output logic                        found,
    output logic [NXT_W-1:0]            res_off,
    output logic [NXT_W-1:0]            res_prev,
    output logic                        err,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic [NXT_W-3:0]            mem_addr,
    output logic [HDR_W-1:0]            mem_wdata,
    input  logic [HDR_W-1:0]            mem_rdata
);
    localparam int unsigned OFF_W  = NXT_W;
    localparam int unsigned STEP_W = $clog2(MAX_STEPS + 1);
    localparam logic [OFF_W-1:0] BASE_PTR = OFF_W'(BASE_OFF);
    localparam logic [OFF_W-1:0] LAST_PTR = OFF_W'(CFG_BYTES - 8);

    typedef struct packed {
        capw_state_e       state;
        logic              append;
        logic [ID_W-1:0]   key;
        logic [VER_W-1:0]  ver;
        logic [OFF_W-1:0]  new_off;
        logic [OFF_W-1:0]  cur;
        logic [OFF_W-1:0]  prev;
        logic [OFF_W-1:0]  keep_next;
        logic [ID_W-1:0]   tail_id;
        logic [VER_W-1:0]  tail_ver;
        logic [STEP_W-1:0] steps;
        logic              done;
        logic              found;
        logic              err;
        logic [OFF_W-1:0]  res_off;
        logic [OFF_W-1:0]  res_prev;
    } walk_st_t;

    walk_st_t  st_d, st_q;
    capw_hdr_t rd_hdr;
    logic      link_ok;
    logic      args_ok;
    logic      last_step;

    assign rd_hdr = capw_hdr_t'(mem_rdata);

    capw_link_check #(
        .BASE_OFF (BASE_OFF),
        .CFG_BYTES(CFG_BYTES),
        .OFF_W    (OFF_W)
    ) u_link (
        .ptr     (rd_hdr.nxt),
        .in_range(link_ok)
    );

    capw_arg_check #(
        .BASE_OFF (BASE_OFF),
        .CFG_BYTES(CFG_BYTES),
        .MIN_SIZE (MIN_SIZE),
        .OFF_W    (OFF_W)
    ) u_args (
        .off    (cmd_off),
        .size   (cmd_size),
        .args_ok(args_ok)
    );

    // The header just read is the last one the walk may visit.
    assign last_step = ({1'b0, st_q.steps} + 1'b1) >= (STEP_W+1)'(MAX_STEPS);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    st_d.append    = (cmd_op == OP_APPEND);
                    st_d.key       = cmd_id;
                    st_d.ver       = cmd_ver;
                    st_d.new_off   = cmd_off;
                    st_d.cur       = BASE_PTR;
                    st_d.prev      = '0;
                    st_d.keep_next = '0;
                    st_d.steps     = '0;
                    st_d.found     = 1'b0;
                    st_d.err       = 1'b0;
                    st_d.res_off   = '0;
                    st_d.res_prev  = '0;
                    if (cmd_op == OP_APPEND && !args_ok) begin
                        st_d.err  = 1'b1;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.state = S_READ;
                    end
                end
            end
            S_READ: st_d.state = S_CHECK;
            S_CHECK: begin
                st_d.state = S_IDLE;
                if (st_q.append && st_q.new_off == BASE_PTR) begin
                    // Head replacement keeps the stored link.
                    st_d.keep_next = rd_hdr.nxt;
                    st_d.prev      = '0;
                    st_d.state     = S_WR_NEW;
                end else if (st_q.steps == '0 && mem_rdata == '0) begin
                    st_d.done = 1'b1;
                    st_d.err  = st_q.append;
                end else if (!st_q.append && st_q.key != '0 &&
                             rd_hdr.id == st_q.key) begin
                    st_d.done     = 1'b1;
                    st_d.found    = 1'b1;
                    st_d.res_off  = st_q.cur;
                    st_d.res_prev = st_q.prev;
                end else if (rd_hdr.nxt == '0) begin
                    if (st_q.append) begin
                        st_d.prev      = st_q.cur;
                        st_d.tail_id   = rd_hdr.id;
                        st_d.tail_ver  = rd_hdr.ver;
                        st_d.keep_next = '0;
                        st_d.state     = S_WR_TAIL;
                    end else begin
                        st_d.done     = 1'b1;
                        st_d.res_prev = st_q.cur;
                    end
                end else if (!link_ok || last_step) begin
                    st_d.done = 1'b1;
                    st_d.err  = 1'b1;
                end else begin
                    st_d.prev  = st_q.cur;
                    st_d.cur   = rd_hdr.nxt;
                    st_d.steps = st_q.steps + 1'b1;
                    st_d.state = S_READ;
                end
            end
            S_WR_TAIL: st_d.state = S_WR_NEW;
            S_WR_NEW: begin
                st_d.state    = S_IDLE;
                st_d.done     = 1'b1;
                st_d.res_off  = st_q.new_off;
                st_d.res_prev = st_q.prev;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = st_q.cur[OFF_W-1:2];
        mem_wdata = '0;
        case (st_q.state)
            S_READ: mem_rd = 1'b1;
            S_WR_TAIL: begin
                mem_wr    = 1'b1;
                mem_addr  = st_q.prev[OFF_W-1:2];
                mem_wdata = {st_q.new_off, st_q.tail_ver, st_q.tail_id};
            end
            S_WR_NEW: begin
                mem_wr    = 1'b1;
                mem_addr  = st_q.new_off[OFF_W-1:2];
                mem_wdata = {st_q.keep_next, st_q.ver, st_q.key};
            end
            default: ;
        endcase
    end

    assign busy     = (st_q.state != S_IDLE);
    assign done     = st_q.done;
    assign found    = st_q.found;
    assign err      = st_q.err;
    assign res_off  = st_q.res_off;
    assign res_prev = st_q.res_prev;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                         // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                         // R10
    AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (st_q.cur >= BASE_PTR && st_q.cur <= LAST_PTR));             // R5
    AST_STEPS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.steps < STEP_W'(MAX_STEPS));                                        // R6
    AST_ERR_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (!found && res_off == '0 && res_prev == '0));          // R5
    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (st_q.new_off[1:0] == 2'b00 && st_q.new_off >= BASE_PTR));   // R9
    AST_NO_RD_WR_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                                    // R8
endmodule

// File: tb/capw_walker_test.sv
`timescale 1ns/1ps
module capw_walker_test;
    localparam int unsigned STEPS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [12:0] cmd_size = '0;
    logic        busy, done, found, err;
    logic [11:0] res_off, res_prev;
    logic        mem_rd, mem_wr;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [1024];
    logic        poke_en = 1'b0;
    logic        clr_en = 1'b0;
    logic [9:0]  poke_addr = '0;
    logic [31:0] poke_data = '0;
    int          wr_count = 0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        found;
        logic [11:0] off;
        logic [11:0] prev;
        logic        err;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    capw_walker #(.MAX_STEPS(STEPS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
        .busy(busy), .done(done), .found(found), .res_off(res_off),
        .res_prev(res_prev), .err(err), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Configuration memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (clr_en) begin
            for (int i = 0; i < 1024; i++) mem[i] <= '0;
        end else if (poke_en) begin
            mem[poke_addr] <= poke_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every completion pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {38'd0, found, res_off, res_prev, err},
                       {38'd0, e.found, e.off, e.prev, e.err});
            end
        end
    end

    task automatic poke(logic [11:0] byte_off, logic [31:0] data);
        @(negedge clk);
        poke_en   = 1'b1;
        poke_addr = byte_off[11:2];
        poke_data = data;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic clear_mem();
        @(negedge clk);
        clr_en = 1'b1;
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    function automatic logic [31:0] hdr(logic [11:0] nxt, logic [3:0] ver, logic [15:0] id);
        return {nxt, ver, id};
    endfunction

    // Driver: pushes the expected result, issues the command, waits for it.
    task automatic run(string tag, logic op, logic [15:0] id, logic [3:0] ver,
                       logic [11:0] off, logic [12:0] size,
                       logic e_found, logic [11:0] e_off, logic [11:0] e_prev, logic e_err);
        exp_t e;
        e.found = e_found; e.off = e_off; e.prev = e_prev; e.err = e_err;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_ver = ver;
        cmd_off = off; cmd_size = size;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk({tag, " R10 done width"}, {63'd0, done}, 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int wc;
        clear_mem();
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {60'd0, busy, done, found, err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {60'd0, busy, done, found, err}, 64'd0);

        run("R2 find on empty list", 1'b0, 16'h0005, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h0, 1'b0);

        wc = wr_count;
        run("R8 append to empty list off base", 1'b1, 16'h0020, 4'h2, 12'h200, 13'd32, 1'b0, 12'h0, 12'h0, 1'b1);
        chk("R8 no write on empty-list append", 64'(wr_count), 64'(wc));

        run("R7 append at base on empty list", 1'b1, 16'h0010, 4'h1, 12'h100, 13'd16, 1'b0, 12'h100, 12'h0, 1'b0);
        chk("R7 base header", 64'(mem[12'h100 >> 2]), 64'(hdr(12'h0, 4'h1, 16'h0010)));
        run("R3 find head", 1'b0, 16'h0010, 4'h0, 12'h0, 13'h0, 1'b1, 12'h100, 12'h0, 1'b0);

        run("R8 append second", 1'b1, 16'h0020, 4'h2, 12'h200, 13'd32, 1'b0, 12'h200, 12'h100, 1'b0);
        chk("R8 tail relinked", 64'(mem[12'h100 >> 2]), 64'(hdr(12'h200, 4'h1, 16'h0010)));
        chk("R8 new header", 64'(mem[12'h200 >> 2]), 64'(hdr(12'h0, 4'h2, 16'h0020)));
        run("R8 append third", 1'b1, 16'h0030, 4'h3, 12'h300, 13'd8, 1'b0, 12'h300, 12'h200, 1'b0);
        chk("R8 middle relinked", 64'(mem[12'h200 >> 2]), 64'(hdr(12'h300, 4'h2, 16'h0020)));

        run("R3 find middle", 1'b0, 16'h0020, 4'h0, 12'h0, 13'h0, 1'b1, 12'h200, 12'h100, 1'b0);
        run("R3 find last", 1'b0, 16'h0030, 4'h0, 12'h0, 13'h0, 1'b1, 12'h300, 12'h200, 1'b0);
        run("R4 find absent", 1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h300, 1'b0);
        run("R4 find id zero gives tail", 1'b0, 16'h0000, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h300, 1'b0);

        run("R7 replace head", 1'b1, 16'h0040, 4'h4, 12'h100, 13'd8, 1'b0, 12'h100, 12'h0, 1'b0);
        chk("R7 head keeps link", 64'(mem[12'h100 >> 2]), 64'(hdr(12'h200, 4'h4, 16'h0040)));

        wc = wr_count;
        run("R9 size below 8", 1'b1, 16'h0050, 4'h1, 12'h400, 13'd4, 1'b0, 12'h0, 12'h0, 1'b1);
        run("R9 end past space", 1'b1, 16'h0050, 4'h1, 12'h800, 13'h801, 1'b0, 12'h0, 12'h0, 1'b1);
        run("R9 offset below base", 1'b1, 16'h0050, 4'h1, 12'h080, 13'd8, 1'b0, 12'h0, 12'h0, 1'b1);
        run("R9 misaligned offset", 1'b1, 16'h0050, 4'h1, 12'h402, 13'd8, 1'b0, 12'h0, 12'h0, 1'b1);
        chk("R9 no writes on rejected appends", 64'(wr_count), 64'(wc));
        chk("R9 tail untouched", 64'(mem[12'h300 >> 2]), 64'(hdr(12'h0, 4'h3, 16'h0030)));

        run("R9 end exactly at space size", 1'b1, 16'h0055, 4'h1, 12'hFF8, 13'd8, 1'b0, 12'hFF8, 12'h300, 1'b0);
        chk("R8 tail links top", 64'(mem[12'h300 >> 2]), 64'(hdr(12'hFF8, 4'h3, 16'h0030)));
        chk("R8 top header", 64'(mem[12'hFF8 >> 2]), 64'(hdr(12'h0, 4'h1, 16'h0055)));
        run("R5 link to 4088 accepted", 1'b0, 16'h0055, 4'h0, 12'h0, 13'h0, 1'b1, 12'hFF8, 12'h300, 1'b0);

        poke(12'h300, hdr(12'hFFC, 4'h3, 16'h0030));
        run("R5 link above window", 1'b0, 16'h0055, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h0, 1'b1);
        poke(12'h300, hdr(12'h0F0, 4'h3, 16'h0030));
        run("R5 link below window", 1'b0, 16'h0055, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h0, 1'b1);

        // Step-limit scenarios: a chain of exactly STEPS headers.
        clear_mem();
        for (int i = 0; i < 6; i++) begin
            logic [11:0] here;
            logic [11:0] nxt;
            here = 12'h100 + 12'(16 * i);
            nxt  = (i == 5) ? 12'h0 : here + 12'h010;
            poke(here, hdr(nxt, 4'h1, 16'h0061 + 16'(i)));
        end
        run("R6 full-length chain tail", 1'b0, 16'h0000, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h150, 1'b0);
        run("R6 match at last allowed step", 1'b0, 16'h0066, 4'h0, 12'h0, 13'h0, 1'b1, 12'h150, 12'h140, 1'b0);
        poke(12'h150, hdr(12'h160, 4'h1, 16'h0066));
        poke(12'h160, hdr(12'h0, 4'h1, 16'h0067));
        run("R6 chain one too long", 1'b0, 16'h0000, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h0, 1'b1);
        poke(12'h110, hdr(12'h100, 4'h1, 16'h0062));
        run("R6 cyclic list", 1'b0, 16'h0000, 4'h0, 12'h0, 13'h0, 1'b0, 12'h0, 12'h0, 1'b1);

        // A second command while busy must be ignored.
        wc = wr_count;
        exp_q.push_back('{found: 1'b0, off: 12'h0, prev: 12'h0, err: 1'b1});
        tag_q.push_back("R10 walk with overlapping request");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_id = 16'h0000;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R10 busy during walk", {63'd0, busy}, 64'd1);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_id = 16'h0077; cmd_ver = 4'h2;
        cmd_off = 12'h400; cmd_size = 13'd8;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R10 no second completion", 64'(exp_q.size()), 64'd0);
        chk("R10 ignored command wrote nothing", 64'(wr_count), 64'(wc));
        chk("R10 idle afterwards", {63'd0, busy}, 64'd0);

        finish_run();
    end
endmodule